// File: doc/BRIEF.md
# Flat Memory Request Aperture Router

This block sits between a vector unit's flat memory pipe and three destinations: on-chip shared memory, per-work-item private scratch, and global memory. It accepts a request with a flat address, a payload size code and a work-item id. It compares both the first byte and the last byte of the payload against two programmable windows: a shared window and a private window. It then issues one of three outcomes. The request can go to a destination with a rebased offset. For a private hit, the offset is spread across work items and moved into a hidden private region. Otherwise the block raises a one-cycle violation pulse for the trap logic and issues nothing.

Two address modes are supported. In wide mode the address is 64 bits, and the windows are given by inclusive 64KB-granular lower and upper bounds. Addresses outside the canonical low and high halves form a hole, and a request that touches the hole outside both windows is illegal. In narrow mode only the low 32 bits count. Each window is a single 64KB block, and a zero block number switches that window off.

The control is a small state machine. ST_IDLE is the only state that accepts work; acceptance takes it to ST_CLASSIFY. In ST_CLASSIFY the window decision is registered, and the machine moves on to ST_TRAP on a violation, to ST_EXPAND on a private hit, or to ST_ISSUE otherwise. ST_EXPAND registers the private multiply-add and always moves to ST_ISSUE. ST_ISSUE and ST_TRAP each last one cycle and return to ST_IDLE.

Top module: `flat_ap_router`

## Requirements
- R1: After reset, `req_ready` is 1 and both `out_valid` and `trap_pulse` are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` then stays 0 until the outcome is done. For a shared, global or violating request, the outcome is shown for exactly one cycle, in the cycle after the second rising edge counted from and including the accepting edge. A private request is shown one cycle later.
- R3: In wide mode, an address is inside a window when its bits [63:16] lie between the window's lower and upper block numbers, both bounds included. When both the first and the last byte are inside the shared window, `out_dest` is 1 and `out_offset` is the address minus (lower block number × 65536).
- R4: When both bytes are inside the private window, `out_dest` is 2. `out_offset` is (address − window start) × NUM_WI + work-item id × ELEM_BYTES + `hidden_base`, modulo 2^64.
- R5: When neither byte is inside any window and no hole rule applies, `out_dest` is 0. `out_offset` is the address unchanged in wide mode, or its low 32 bits zero-extended in narrow mode.
- R6: In wide mode, a byte whose bits [63:47] are neither all zeros nor all ones lies in the hole. A request with either byte in the hole and neither byte in a window is a violation.
- R7: A request whose first and last bytes are not both inside the same window is a violation. This includes one byte in a window and the other outside it.
- R8: Size code k (0 to 4) means 2^k bytes, and the last byte is the address plus 2^k − 1. Size codes 5 to 7 are violations.
- R9: In narrow mode, address bits [63:32] are ignored. A window covers exactly the 64KB block whose bits [31:16] equal bits [15:0] of its lower block number; a value of zero disables the window. The hole does not apply.
- R10: A violation produces a `trap_pulse` that lasts exactly one cycle, and `out_valid` does not rise for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_narrow | input | 1 | 1 selects 32-bit mode, 0 selects 64-bit mode |
| shr_base_hi | input | 48 | Shared window lower block number (address bits 63:16) |
| shr_limit_hi | input | 48 | Shared window upper block number, inclusive (wide mode) |
| prv_base_hi | input | 48 | Private window lower block number |
| prv_limit_hi | input | 48 | Private window upper block number, inclusive (wide mode) |
| hidden_base | input | 64 | Start of the hidden private region |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Flat address of the first byte |
| req_size | input | 3 | Payload size code, 2^code bytes |
| req_wid | input | 6 | Work-item id |
| out_valid | output | 1 | Routed request issued this cycle |
| out_dest | output | 2 | 0 global, 1 shared, 2 private |
| out_offset | output | 64 | Rebased or expanded offset |
| trap_pulse | output | 1 | Memory violation pulse |

## Verification
The bench sweeps addresses around every window edge in both modes, with every size code. The sweep includes payloads whose last byte crosses a window's upper bound or the top of the canonical low half. A design that checked only the first byte would route these straddling requests instead of trapping them. Off-by-one errors in the inclusive bounds show up as wrong destinations at the exact lower and upper addresses. The sweep also varies the work-item id on private hits, which exposes a wrong expansion term, and it measures the outcome cycle to catch a skipped or doubled pipeline stage. Narrow-mode runs set high address bits that must be ignored and zero a window base, so a design that kept the hole rule or matched block zero routes these requests wrongly.

// File: rtl/flat_ap_pkg.sv
package flat_ap_pkg;

    localparam int GRAN_BITS = 16;

    typedef enum logic [1:0] {
        DST_GLOBAL  = 2'd0,
        DST_SHARED  = 2'd1,
        DST_PRIVATE = 2'd2
    } dest_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_EXPAND,
        ST_ISSUE,
        ST_TRAP
    } state_e;

endpackage

// File: rtl/flat_ap_window.sv
module flat_ap_window
    import flat_ap_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32,
    localparam int HI_W    = ADDR_W - GRAN_BITS,
    localparam int NB_W    = NARROW_W - GRAN_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_narrow,
    input  logic [HI_W-1:0]   lo_blk,
    input  logic [HI_W-1:0]   hi_blk,
    output logic              hit
);

    logic [HI_W-1:0] blk;
    logic            wide_hit;
    logic            narrow_hit;

    assign blk        = addr[ADDR_W-1:GRAN_BITS];
    assign wide_hit   = (blk >= lo_blk) && (blk <= hi_blk);
    assign narrow_hit = (lo_blk[NB_W-1:0] != '0) &&
                        (addr[NARROW_W-1:GRAN_BITS] == lo_blk[NB_W-1:0]);
    assign hit        = mode_narrow ? narrow_hit : wide_hit;

endmodule

// File: rtl/flat_ap_classify.sv
module flat_ap_classify
    import flat_ap_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int VA_BITS  = 48,
    parameter int NARROW_W = 32,
    parameter int MAX_SIZE = 4,
    localparam int HI_W    = ADDR_W - GRAN_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size_code,
    input  logic              mode_narrow,
    input  logic [HI_W-1:0]   shr_base_hi,
    input  logic [HI_W-1:0]   shr_limit_hi,
    input  logic [HI_W-1:0]   prv_base_hi,
    input  logic [HI_W-1:0]   prv_limit_hi,
    output logic              violation,
    output dest_e             dest,
    output logic [ADDR_W-1:0] ofs
);

    localparam int TOP_W = ADDR_W - VA_BITS + 1;

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] pt [2];
    logic [1:0]        shr_hit;
    logic [1:0]        prv_hit;
    logic [1:0]        in_hole;
    logic              size_ok;
    logic [ADDR_W-1:0] narrow_addr;

    assign span    = ADDR_W'(1) << size_code;
    assign pt[0]   = addr;
    assign pt[1]   = addr + span - ADDR_W'(1);
    assign size_ok = (size_code <= 3'(MAX_SIZE));
    assign narrow_addr = {{(ADDR_W-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};

    for (genvar p = 0; p < 2; p++) begin : g_pt
        logic [TOP_W-1:0] top_bits;

        flat_ap_window #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_shr (
            .addr        (pt[p]),
            .mode_narrow (mode_narrow),
            .lo_blk      (shr_base_hi),
            .hi_blk      (shr_limit_hi),
            .hit         (shr_hit[p])
        );

        flat_ap_window #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_prv (
            .addr        (pt[p]),
            .mode_narrow (mode_narrow),
            .lo_blk      (prv_base_hi),
            .hi_blk      (prv_limit_hi),
            .hit         (prv_hit[p])
        );

        assign top_bits   = pt[p][ADDR_W-1:VA_BITS-1];
        assign in_hole[p] = !mode_narrow && (top_bits != '0) && (top_bits != '1);
    end

    always_comb begin
        violation = 1'b0;
        dest      = DST_GLOBAL;
        ofs       = '0;
        if (!size_ok) begin
            violation = 1'b1;
        end else if (shr_hit == 2'b11) begin
            dest = DST_SHARED;
            ofs  = mode_narrow ? {{(ADDR_W-GRAN_BITS){1'b0}}, addr[GRAN_BITS-1:0]}
                               : addr - {shr_base_hi, {GRAN_BITS{1'b0}}};
        end else if (prv_hit == 2'b11) begin
            dest = DST_PRIVATE;
            ofs  = mode_narrow ? {{(ADDR_W-GRAN_BITS){1'b0}}, addr[GRAN_BITS-1:0]}
                               : addr - {prv_base_hi, {GRAN_BITS{1'b0}}};
        end else if ((shr_hit | prv_hit) != 2'b00) begin
            violation = 1'b1;
        end else if (in_hole != 2'b00) begin
            violation = 1'b1;
        end else begin
            dest = DST_GLOBAL;
            ofs  = mode_narrow ? narrow_addr : addr;
        end
    end

endmodule

// File: rtl/flat_ap_expand.sv
module flat_ap_expand #(
    parameter int ADDR_W     = 64,
    parameter int NUM_WI     = 64,
    parameter int ELEM_BYTES = 4,
    localparam int WID_W     = $clog2(NUM_WI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ofs_in,
    input  logic [WID_W-1:0]  wid,
    input  logic [ADDR_W-1:0] hidden_base,
    output logic [ADDR_W-1:0] ofs_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_out <= '0;
        end else if (load) begin
            ofs_out <= ofs_in * ADDR_W'(NUM_WI)
                     + ADDR_W'(wid) * ADDR_W'(ELEM_BYTES)
                     + hidden_base;
        end
    end

    // R4
    exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ofs_out));

endmodule

// File: rtl/flat_ap_router.sv
module flat_ap_router
    import flat_ap_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int VA_BITS    = 48,
    parameter int NARROW_W   = 32,
    parameter int NUM_WI     = 64,
    parameter int ELEM_BYTES = 4,
    parameter int MAX_SIZE   = 4,
    localparam int WID_W     = $clog2(NUM_WI),
    localparam int HI_W      = ADDR_W - GRAN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_narrow,
    input  logic [HI_W-1:0]   shr_base_hi,
    input  logic [HI_W-1:0]   shr_limit_hi,
    input  logic [HI_W-1:0]   prv_base_hi,
    input  logic [HI_W-1:0]   prv_limit_hi,
    input  logic [ADDR_W-1:0] hidden_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [WID_W-1:0]  req_wid,
    output logic              out_valid,
    output logic [1:0]        out_dest,
    output logic [ADDR_W-1:0] out_offset,
    output logic              trap_pulse
);

    state_e            state;
    state_e            nxt;
    logic [ADDR_W-1:0] cap_addr;
    logic [2:0]        cap_size;
    logic [WID_W-1:0]  cap_wid;
    dest_e             res_dest;
    logic [ADDR_W-1:0] res_ofs;
    logic              cls_viol;
    dest_e             cls_dest;
    logic [ADDR_W-1:0] cls_ofs;
    logic [ADDR_W-1:0] exp_ofs;

    flat_ap_classify #(
        .ADDR_W   (ADDR_W),
        .VA_BITS  (VA_BITS),
        .NARROW_W (NARROW_W),
        .MAX_SIZE (MAX_SIZE)
    ) u_classify (
        .addr         (cap_addr),
        .size_code    (cap_size),
        .mode_narrow  (mode_narrow),
        .shr_base_hi  (shr_base_hi),
        .shr_limit_hi (shr_limit_hi),
        .prv_base_hi  (prv_base_hi),
        .prv_limit_hi (prv_limit_hi),
        .violation    (cls_viol),
        .dest         (cls_dest),
        .ofs          (cls_ofs)
    );

    flat_ap_expand #(
        .ADDR_W     (ADDR_W),
        .NUM_WI     (NUM_WI),
        .ELEM_BYTES (ELEM_BYTES)
    ) u_expand (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (state == ST_EXPAND),
        .ofs_in      (res_ofs),
        .wid         (cap_wid),
        .hidden_base (hidden_base),
        .ofs_out     (exp_ofs)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = ST_CLASSIFY;
            ST_CLASSIFY: begin
                if (cls_viol)                     nxt = ST_TRAP;
                else if (cls_dest == DST_PRIVATE) nxt = ST_EXPAND;
                else                              nxt = ST_ISSUE;
            end
            ST_EXPAND:   nxt = ST_ISSUE;
            ST_ISSUE:    nxt = ST_IDLE;
            ST_TRAP:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // request capture and classification result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_size <= '0;
            cap_wid  <= '0;
            res_dest <= DST_GLOBAL;
            res_ofs  <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                cap_addr <= req_addr;
                cap_size <= req_size;
                cap_wid  <= req_wid;
            end
            if (state == ST_CLASSIFY) begin
                res_dest <= cls_dest;
                res_ofs  <= cls_ofs;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        out_valid  = 1'b0;
        trap_pulse = 1'b0;
        out_dest   = 2'd0;
        out_offset = '0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_CLASSIFY: ;
            ST_EXPAND:   ;
            ST_ISSUE: begin
                out_valid  = 1'b1;
                out_dest   = res_dest;
                out_offset = (res_dest == DST_PRIVATE) ? exp_ofs : res_ofs;
            end
            ST_TRAP:     trap_pulse = 1'b1;
            default:     ;
        endcase
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && req_ready));

    // R10
    trap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> (!trap_pulse && !out_valid && req_ready));

    // R4
    priv_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dest == 2'd2) |-> $past(state == ST_EXPAND));

endmodule

// File: tb/flat_ap_router_bench.sv
module flat_ap_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_narrow = 1'b0;
    logic [47:0] shr_base_hi = '0, shr_limit_hi = '0, prv_base_hi = '0, prv_limit_hi = '0;
    logic [63:0] hidden_base = 64'h0000_0000_4000_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [5:0]  req_wid = '0;
    logic        out_valid;
    logic [1:0]  out_dest;
    logic [63:0] out_offset;
    logic        trap_pulse;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    flat_ap_router u_flat_ap_router (
        .clk (clk), .rst_n (rst_n), .mode_narrow (mode_narrow),
        .shr_base_hi (shr_base_hi), .shr_limit_hi (shr_limit_hi),
        .prv_base_hi (prv_base_hi), .prv_limit_hi (prv_limit_hi),
        .hidden_base (hidden_base), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_size (req_size), .req_wid (req_wid),
        .out_valid (out_valid), .out_dest (out_dest), .out_offset (out_offset),
        .trap_pulse (trap_pulse)
    );

    logic [63:0] a_wide [15] = '{
        64'h0001_0000_0000_0000, 64'h0001_0000_0000_0001, 64'h0001_0000_0000_FFF4,
        64'h0001_0000_FFFF_FFF0, 64'h0001_0000_FFFF_FFFC, 64'h0001_0000_FFFF_FFFF,
        64'h0000_FFFF_FFFF_FFF8, 64'h0002_0000_0000_0000, 64'h0002_0000_0000_1234,
        64'h0002_0000_FFFF_FFF8, 64'h0002_0000_FFFF_FFFF, 64'h0000_0000_0000_1000,
        64'h0000_7FFF_FFFF_FFF8, 64'hFFFF_8000_0000_0000, 64'hFFFF_7FFF_FFFF_FFFC
    };

    logic [63:0] a_narrow [10] = '{
        64'h0000_0000_0010_0000, 64'h0000_0000_0010_FFF0, 64'h0000_0000_0010_FFFC,
        64'h0000_0000_000F_FFFE, 64'h0000_0000_0020_0000, 64'h0000_0000_0020_FFFF,
        64'h0000_0000_0030_0000, 64'hABCD_0000_0010_0004, 64'h0000_0000_FFFF_FFFE,
        64'h0000_0000_0000_1234
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic bit in_win(input logic [63:0] a, input logic [47:0] lo,
                                  input logic [47:0] hi);
        if (mode_narrow) return (lo[15:0] != 16'h0) && (a[31:16] == lo[15:0]);
        return (a[63:16] >= lo) && (a[63:16] <= hi);
    endfunction

    function automatic bit in_hole(input logic [63:0] a);
        if (mode_narrow) return 1'b0;
        return !(a[63:47] == 17'h0 || a[63:47] == 17'h1FFFF);
    endfunction

    function automatic void model(input logic [63:0] a, input logic [2:0] sz,
                                  input logic [5:0] wid, output bit viol,
                                  output logic [1:0] dest, output logic [63:0] ofs);
        logic [63:0] last;
        logic [63:0] rel;
        viol = 1'b0; dest = 2'd0; ofs = '0;
        if (sz > 3'd4) begin viol = 1'b1; return; end
        last = a + (64'd1 << sz) - 64'd1;
        if (in_win(a, shr_base_hi, shr_limit_hi) && in_win(last, shr_base_hi, shr_limit_hi)) begin
            dest = 2'd1;
            ofs  = mode_narrow ? {48'h0, a[15:0]} : a - {shr_base_hi, 16'h0};
        end else if (in_win(a, prv_base_hi, prv_limit_hi) && in_win(last, prv_base_hi, prv_limit_hi)) begin
            dest = 2'd2;
            rel  = mode_narrow ? {48'h0, a[15:0]} : a - {prv_base_hi, 16'h0};
            ofs  = rel * 64'd64 + {58'h0, wid} * 64'd4 + hidden_base;
        end else if (in_win(a, shr_base_hi, shr_limit_hi) || in_win(last, shr_base_hi, shr_limit_hi) ||
                     in_win(a, prv_base_hi, prv_limit_hi) || in_win(last, prv_base_hi, prv_limit_hi)) begin
            viol = 1'b1;
        end else if (in_hole(a) || in_hole(last)) begin
            viol = 1'b1;
        end else begin
            ofs = mode_narrow ? {32'h0, a[31:0]} : a;
        end
    endfunction

    task automatic run_req(input logic [63:0] a, input logic [2:0] sz, input logic [5:0] wid);
        bit          e_viol;
        logic [1:0]  e_dest;
        logic [63:0] e_ofs;
        int          lat;
        int          e_lat;
        bit          seen;
        model(a, sz, wid, e_viol, e_dest, e_ofs);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_wid = wid;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 busy after accept", {63'h0, req_ready}, 64'h0);
        lat = 0; seen = 1'b0;
        for (int c = 1; c <= 8 && !seen; c++) begin
            @(negedge clk);
            if (out_valid || trap_pulse) begin seen = 1'b1; lat = c; end
        end
        if (!seen) begin
            check(1'b0, "R2 no outcome", 64'h0, 64'h1);
            return;
        end
        e_lat = (!e_viol && e_dest == 2'd2) ? 2 : 1;
        check(lat == e_lat, (e_dest == 2'd2) ? "R4 private latency" : "R2 latency",
              64'(lat), 64'(e_lat));
        if (e_viol) begin
            // R6 R7 R8 R10
            check(trap_pulse && !out_valid, "R10 violation expected", {62'h0, trap_pulse, out_valid},
                  64'h2);
        end else begin
            check(out_valid && !trap_pulse && out_dest == e_dest,
                  (e_dest == 2'd1) ? "R3 dest" : (e_dest == 2'd2) ? "R4 dest" : "R5 dest",
                  {61'h0, trap_pulse, out_dest}, {62'h0, e_dest});
            check(out_offset == e_ofs, mode_narrow ? "R9 offset" : "R3 R4 R5 offset",
                  out_offset, e_ofs);
        end
        @(negedge clk);
        check(!out_valid && !trap_pulse && req_ready, "R10 R2 single cycle outcome",
              {61'h0, out_valid, trap_pulse, req_ready}, 64'h1);
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog expired", 64'h0, 64'h1);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && !out_valid && !trap_pulse, "R1 reset state",
              {61'h0, req_ready, out_valid, trap_pulse}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !out_valid && !trap_pulse, "R1 after release",
              {61'h0, req_ready, out_valid, trap_pulse}, 64'h4);

        // wide mode: windows inside the hole
        mode_narrow  = 1'b0;
        shr_base_hi  = 48'h0001_0000_0000; shr_limit_hi = 48'h0001_0000_FFFF;
        prv_base_hi  = 48'h0002_0000_0000; prv_limit_hi = 48'h0002_0000_FFFF;
        for (int i = 0; i < 15; i++)
            for (int s = 0; s < 8; s++)
                run_req(a_wide[i], 3'(s), 6'((i * 7 + s * 13) % 64));

        // narrow mode: single 64KB windows, upper bits ignored
        mode_narrow = 1'b1;
        shr_base_hi = 48'h0000_0000_0010; shr_limit_hi = 48'h0;
        prv_base_hi = 48'h0000_0000_0020; prv_limit_hi = 48'h0;
        for (int i = 0; i < 10; i++)
            for (int s = 0; s < 6; s++)
                run_req(a_narrow[i], 3'(s), 6'((i * 5 + s * 11) % 64));

        // R9 zero block number disables the shared window
        shr_base_hi = 48'h0;
        run_req(64'h0000_0000_0000_0004, 3'd2, 6'd3);
        run_req(64'h0000_0000_0010_0000, 3'd2, 6'd3);
        run_req(64'h0000_0000_0020_0010, 3'd3, 6'd63);

        finish_up();
    end

endmodule